// File: doc/BRIEF.md
# Bit-Bang Parallel Port Engine

This block replaces the serial function of a group of port lines with a byte-wide general-purpose I/O port. Bytes offered on an input stream are placed on the port one at a time, never faster than a pacing enable pulse allows. Pin states come back as bytes on an output stream. A per-bit direction mask decides which lines the engine drives and which it leaves floating as inputs. Every input line passes through a two-stage synchronizer before it is sampled.

Two read policies are offered. In free-running mode a sample is taken on every pacing tick, whether or not a byte was written. In lockstep mode a sample is taken only as a consequence of a write, on the tick after the byte was driven, so each returned byte answers exactly one written byte. Active-low write and read strobes mark every port access so that outside logic can be clocked by them. When the consumer of the output stream holds off, the engine waits instead of losing a sample. The pacing timer and the transport that carries the byte streams lie outside the block.

Top module: `bitbang_port`

## Requirements
- R1: While reset is held and immediately after it, `pin_out` is 0, both strobes are high (1) and `rd_valid` is 0.
- R2: `pin_oe[i]` equals `dir_mask[i]` at all times; a 1 means the line is driven from `pin_out[i]`, a 0 means it is an input.
- R3: A byte is taken from the input stream (`wr_valid` and `wr_ready` both 1 at a rising clock edge) only in a cycle where `tick` is 1, at most one per tick, and `pin_out` takes that byte at that same edge and changes at no other time.
- R4: For each accepted byte `wr_strobe_n` falls one clock after the accepting edge and rises again at the edge of the next tick, so it stays low for one tick period minus one clock; it never falls without an accepted byte.
- R5: For each sample taken `rd_strobe_n` falls one clock after the sampling edge and rises at the edge of the next tick, so it stays low for one tick period minus one clock; it never falls without a sample.
- R6: With `mode_sync` = 1 (lockstep), a tick that accepts a byte takes no sample; the next tick with a free output slot samples the pins and pushes exactly one byte, and no byte is accepted on that sampling tick. The returned byte equals `(written & dir_mask) | (external & ~dir_mask)`.
- R7: With `mode_sync` = 0 (free-running), every tick with a free output slot takes a sample, whether or not a byte is written on that tick; a byte accepted on the same tick is not yet visible in that sample but is visible in the next.
- R8: While `rd_valid` is 1 and `rd_ready` is 0 the engine stalls: `rd_data` holds its value, `wr_ready` is 0, no byte is accepted and no sample is taken; once the byte is consumed, sampling resumes with the current pin state.
- R9: Each input line passes two synchronizer flops before it is sampled: a line change applied before the clock edge two edges ahead of a sampling edge reaches that sample, while a change applied just one edge ahead of it does not and appears in the following sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sync | input | 1 | 1 = lockstep sampling after each write, 0 = free-running sampling on every tick |
| dir_mask | input | WIDTH | Per-bit direction, 1 = drive, 0 = input |
| tick | input | 1 | Single-cycle pacing enable from the external timer |
| wr_valid | input | 1 | Input stream byte valid |
| wr_data | input | WIDTH | Input stream byte to drive onto the port |
| wr_ready | output | 1 | Input stream byte accepted at this edge when valid |
| rd_valid | output | 1 | Output stream sample valid |
| rd_data | output | WIDTH | Sampled pin state |
| rd_ready | input | 1 | Output stream consumer ready |
| pin_in | input | WIDTH | Raw pin levels from the pads |
| pin_out | output | WIDTH | Levels driven onto the pads |
| pin_oe | output | WIDTH | Per-bit output enable for the pads |
| wr_strobe_n | output | 1 | Active-low write strobe |
| rd_strobe_n | output | 1 | Active-low read strobe |

## Verification
The bench builds the engine with its default byte width of eight lines and two synchronizer stages, driven by a pacing tick every six clocks. That period is long enough for a driven value to loop back through the pads and the synchronizer before the next tick, so lockstep samples can be predicted exactly, while being short enough that strobe widths of five clocks and back-to-back ticks are reached within a short run. The tick phase is known to the bench, which lets it place pin changes exactly one and two edges ahead of a sampling edge to pin down the synchronizer depth.

// File: rtl/bitbang_pkg.sv
package bitbang_pkg;

    localparam int unsigned BB_DEFAULT_WIDTH  = 8;
    localparam int unsigned BB_DEFAULT_STAGES = 2;

    // Sampling policy
    typedef enum logic {
        MODE_FREE     = 1'b0,
        MODE_LOCKSTEP = 1'b1
    } bb_mode_e;

    // Work done at one pacing tick
    typedef struct packed {
        logic drive;
        logic sample;
    } bb_action_t;

    // go: tick with a free output slot; pending: lockstep sample owed
    function automatic bb_action_t bb_decide(
        input bb_mode_e mode,
        input logic     go,
        input logic     pending,
        input logic     wr_valid
    );
        bb_action_t a;
        if (mode == MODE_FREE) begin
            a.sample = go;
            a.drive  = go & wr_valid;
        end else begin
            a.sample = go & pending;
            a.drive  = go & ~pending & wr_valid;
        end
        return a;
    endfunction

endpackage

// File: rtl/bitbang_sync.sv
module bitbang_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    localparam int unsigned LAST = STAGES - 1;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain_q <= '0;
            end else if (STAGES == 1) begin
                chain_q <= d_async[b];
            end else begin
                chain_q <= {chain_q[STAGES-2:0], d_async[b]};
            end
        end

        assign q_sync[b] = chain_q[LAST];
    end
endmodule

// File: rtl/bitbang_seq.sv
module bitbang_seq
    import bitbang_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  bb_mode_e         mode,
    input  logic             slot_free,
    input  logic             wr_valid,
    input  logic [WIDTH-1:0] wr_data,
    output logic             wr_ready,
    output bb_action_t       act,
    output logic [WIDTH-1:0] port_q
);
    logic go;
    logic pending_q;

    always_comb begin
        go       = tick & slot_free;
        act      = bb_decide(mode, go, pending_q, wr_valid);
        wr_ready = go & ((mode == MODE_FREE) | ~pending_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= 1'b0;
            port_q    <= '0;
        end else begin
            if (act.drive) begin
                port_q <= wr_data;
            end
            if (mode == MODE_FREE) begin
                pending_q <= 1'b0;
            end else if (act.drive) begin
                pending_q <= 1'b1;
            end else if (act.sample) begin
                pending_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/bitbang_strobe.sv
module bitbang_strobe (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic fire,
    output logic strobe_n
);
    logic arm_q;

    // Falls the clock after an access, released by the following tick.
    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_n <= 1'b1;
            arm_q    <= 1'b0;
        end else if (tick) begin
            strobe_n <= 1'b1;
            arm_q    <= fire;
        end else if (arm_q) begin
            strobe_n <= 1'b0;
            arm_q    <= 1'b0;
        end
    end
endmodule

// File: rtl/bitbang_slot.sv
module bitbang_slot #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic [WIDTH-1:0] sample_in,
    input  logic             rd_ready,
    output logic             rd_valid,
    output logic [WIDTH-1:0] rd_data,
    output logic             slot_free
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else if (capture) begin
            rd_valid <= 1'b1;
            rd_data  <= sample_in;
        end else if (rd_ready) begin
            rd_valid <= 1'b0;
        end
    end

    assign slot_free = ~rd_valid;
endmodule

// File: rtl/bitbang_port.sv
module bitbang_port
    import bitbang_pkg::*;
#(
    parameter int unsigned WIDTH       = BB_DEFAULT_WIDTH,
    parameter int unsigned SYNC_STAGES = BB_DEFAULT_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_sync,
    input  logic [WIDTH-1:0] dir_mask,
    input  logic             tick,
    input  logic             wr_valid,
    input  logic [WIDTH-1:0] wr_data,
    output logic             wr_ready,
    output logic             rd_valid,
    output logic [WIDTH-1:0] rd_data,
    input  logic             rd_ready,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe,
    output logic             wr_strobe_n,
    output logic             rd_strobe_n
);
    bb_mode_e         mode;
    bb_action_t       act;
    logic             slot_free;
    logic [WIDTH-1:0] pins_synced;
    logic [WIDTH-1:0] port_q;

    assign mode = mode_sync ? MODE_LOCKSTEP : MODE_FREE;

    bitbang_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst     (rst),
        .d_async (pin_in),
        .q_sync  (pins_synced)
    );

    bitbang_seq #(.WIDTH(WIDTH)) seq_i (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .mode      (mode),
        .slot_free (slot_free),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .wr_ready  (wr_ready),
        .act       (act),
        .port_q    (port_q)
    );

    bitbang_slot #(.WIDTH(WIDTH)) slot_i (
        .clk       (clk),
        .rst       (rst),
        .capture   (act.sample),
        .sample_in (pins_synced),
        .rd_ready  (rd_ready),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .slot_free (slot_free)
    );

    bitbang_strobe wr_stb_i (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .fire     (act.drive),
        .strobe_n (wr_strobe_n)
    );

    bitbang_strobe rd_stb_i (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .fire     (act.sample),
        .strobe_n (rd_strobe_n)
    );

    assign pin_out = port_q;
    assign pin_oe  = dir_mask;
endmodule

// File: rtl/bitbang_port_chk.sv
module bitbang_port_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             mode_sync,
    input logic             tick,
    input logic             wr_valid,
    input logic             wr_ready,
    input logic             rd_valid,
    input logic             rd_ready,
    input logic [WIDTH-1:0] rd_data,
    input logic [WIDTH-1:0] pin_out,
    input logic             wr_strobe_n,
    input logic             rd_strobe_n
);
    // R3
    accept_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready) |-> tick);

    // R3
    pin_change_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(pin_out) |-> $past(wr_valid && wr_ready));

    // R4
    wr_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_strobe_n) |-> $past(tick));

    // R4
    wr_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(wr_strobe_n) |-> $past(tick, 2));

    // R5
    rd_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_strobe_n) |-> $past(tick, 2));

    // R6
    lockstep_split_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_sync && wr_valid && wr_ready) |=> !rd_valid);

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    // R8
    stall_no_accept_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> !wr_ready);
endmodule

bind bitbang_port bitbang_port_chk #(.WIDTH(WIDTH)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .mode_sync   (mode_sync),
    .tick        (tick),
    .wr_valid    (wr_valid),
    .wr_ready    (wr_ready),
    .rd_valid    (rd_valid),
    .rd_ready    (rd_ready),
    .rd_data     (rd_data),
    .pin_out     (pin_out),
    .wr_strobe_n (wr_strobe_n),
    .rd_strobe_n (rd_strobe_n)
);

// File: tb/bitbang_port_tb_top.sv
`timescale 1ns/1ps
module bitbang_port_tb_top;
    localparam int TICK_DIV = 6;
    localparam int WDOG     = 100000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_sync = 1'b0;
    logic [7:0] dir_mask = 8'h00;
    logic       tick = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wr_ready;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       rd_ready = 1'b1;
    logic [7:0] pin_in;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;
    logic       wr_strobe_n;
    logic       rd_strobe_n;
    logic [7:0] ext = 8'h00;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int tcnt = 0;
    bit done = 0;

    always #10 clk = ~clk;

    // pad model: driven bits loop back, the rest come from outside
    assign pin_in = (pin_out & pin_oe) | (ext & ~pin_oe);

    always @(posedge clk) begin
        cyc  <= cyc + 1;
        tcnt <= (tcnt == TICK_DIV - 1) ? 0 : tcnt + 1;
        tick <= rst ? 1'b0 : (tcnt == TICK_DIV - 1);
    end

    bitbang_port dut_i (
        .clk(clk), .rst(rst), .mode_sync(mode_sync), .dir_mask(dir_mask),
        .tick(tick), .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .wr_strobe_n(wr_strobe_n), .rd_strobe_n(rd_strobe_n)
    );

    function automatic logic [7:0] expect_pins(logic [7:0] drv, logic [7:0] m, logic [7:0] e);
        return (drv & m) | (e & ~m);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // strobe pulse width and count monitor
    int wr_run = 0, rd_run = 0, wr_falls = 0, rd_falls = 0, accepts = 0, samples = 0;
    logic wr_prev = 1'b1, rd_prev = 1'b1;
    always @(negedge clk) begin
        if (!rst) begin
            if (wr_valid && wr_ready) accepts++;
            if (rd_valid && rd_ready) samples++;
            if (!wr_strobe_n) begin
                if (wr_prev) wr_falls++;
                wr_run++;
            end else if (wr_run > 0) begin
                check(wr_run == TICK_DIV - 1, "R4 wr strobe width", wr_run, TICK_DIV - 1);
                wr_run = 0;
            end
            if (!rd_strobe_n) begin
                if (rd_prev) rd_falls++;
                rd_run++;
            end else if (rd_run > 0) begin
                check(rd_run == TICK_DIV - 1, "R5 rd strobe width", rd_run, TICK_DIV - 1);
                rd_run = 0;
            end
            wr_prev = wr_strobe_n;
            rd_prev = rd_strobe_n;
        end
    end

    always @(negedge clk) begin
        if (cyc > WDOG && !done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG);
            finish_up();
        end
    end

    // called and returns at a negedge
    task automatic do_write(input logic [7:0] b);
        wr_data  = b;
        wr_valid = 1'b1;
        while (!wr_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic wait_sample(output logic [7:0] d);
        while (!rd_valid) @(negedge clk);
        d = rd_data;
        @(negedge clk);
    endtask

    task automatic wait_tick_seen();
        @(negedge clk);
        while (!tick) @(negedge clk);
    endtask

    logic [7:0] d, m, e, b, expv;

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        // R1: state during reset
        check(pin_out == 8'h00, "R1 pin_out in reset", pin_out, 0);
        check(wr_strobe_n && rd_strobe_n, "R1 strobes in reset", {wr_strobe_n, rd_strobe_n}, 3);
        rst = 1'b0;
        @(negedge clk);
        check(rd_valid == 1'b0, "R1 rd_valid after reset", rd_valid, 0);
        check(pin_out == 8'h00, "R1 pin_out after reset", pin_out, 0);

        // R2: direction mask per bit
        for (int i = 0; i < 4; i++) begin
            dir_mask = 8'h01 << (2 * i) | 8'h80 >> i;
            #1;
            check(pin_oe == dir_mask, "R2 pin_oe", pin_oe, dir_mask);
        end

        // R6: directed lockstep case
        mode_sync = 1'b1;
        dir_mask  = 8'hF0;
        ext       = 8'h5A;
        do_write(8'hC3);
        check(pin_out == 8'hC3, "R3 pin_out after accept", pin_out, 8'hC3);
        check(rd_valid == 1'b0, "R6 no sample on write tick", rd_valid, 0);
        wait_sample(d);
        check(d == 8'hCA, "R6 lockstep sample", d, 8'hCA);

        // R6: random lockstep traffic
        for (int i = 0; i < 30; i++) begin
            m = 8'($urandom);
            e = 8'($urandom);
            b = 8'($urandom);
            dir_mask = m;
            ext = e;
            do_write(b);
            check(pin_out == b, "R3 pin_out random", pin_out, b);
            wait_sample(d);
            expv = expect_pins(b, m, e);
            check(d == expv, "R6 lockstep random", d, expv);
        end

        // R7: free-running mode
        mode_sync = 1'b0;
        dir_mask  = 8'h0F;
        ext       = 8'hA0;
        wait_sample(d);
        wait_sample(d);
        wait_sample(d);
        expv = expect_pins(pin_out, 8'h0F, 8'hA0);
        check(d == expv, "R7 free-running sample no write", d, expv);
        do_write(8'h35);
        wait_sample(d);
        check(d == expv, "R7 same-tick sample holds old", d, expv);
        wait_sample(d);
        check(d == 8'hA5, "R7 next sample shows write", d, 8'hA5);

        // R9: synchronizer depth
        dir_mask = 8'h00;
        ext = 8'h11;
        repeat (3 * TICK_DIV) @(negedge clk);
        wait_tick_seen();
        repeat (TICK_DIV - 1) @(negedge clk);
        ext = 8'h22;
        wait_sample(d);
        check(d == 8'h11, "R9 late change misses sample", d, 8'h11);
        wait_sample(d);
        check(d == 8'h22, "R9 late change in next sample", d, 8'h22);
        wait_tick_seen();
        repeat (TICK_DIV - 2) @(negedge clk);
        ext = 8'h33;
        wait_sample(d);
        check(d == 8'h33, "R9 early change reaches sample", d, 8'h33);

        // R8: stall with consumer not ready
        ext = 8'h44;
        repeat (3 * TICK_DIV) @(negedge clk);
        rd_ready = 1'b0;
        while (!rd_valid) @(negedge clk);
        d = rd_data;
        check(d == 8'h44, "R8 sample before stall", d, 8'h44);
        begin
            int wr_f0, rd_f0, rdy_seen;
            logic [7:0] p0;
            wr_f0 = wr_falls;
            rd_f0 = rd_falls;
            p0 = pin_out;
            rdy_seen = 0;
            ext = 8'h66;
            wr_data = 8'h77;
            wr_valid = 1'b1;
            repeat (3 * TICK_DIV) begin
                @(negedge clk);
                if (wr_ready) rdy_seen++;
            end
            check(rdy_seen == 0, "R8 wr_ready low in stall", rdy_seen, 0);
            check(rd_valid && rd_data == 8'h44, "R8 rd_data held", rd_data, 8'h44);
            check(pin_out == p0, "R8 no write in stall", pin_out, p0);
            check(wr_falls == wr_f0, "R8 no wr strobe in stall", wr_falls, wr_f0);
            check(rd_falls == rd_f0 + 1 || rd_falls == rd_f0, "R8 no rd strobe in stall", rd_falls, rd_f0);
            wr_valid = 1'b0;
        end
        rd_ready = 1'b1;
        @(negedge clk);
        wait_sample(d);
        check(d == 8'h66, "R8 resumes with current pins", d, 8'h66);

        // quiesce, then compare strobe counts with traffic
        mode_sync = 1'b1;
        repeat (4 * TICK_DIV) @(negedge clk);
        check(wr_falls == accepts, "R4 one wr strobe per byte", wr_falls, accepts);
        check(rd_falls == samples, "R5 one rd strobe per sample", rd_falls, samples);
        finish_up();
    end
endmodule